// File: doc/BRIEF.md
# Converter Serial Readout Port

This block is the serial output side of a sampling converter. Each time the conversion sequencer finishes, it pulses a latch strobe. The block then captures the result word into its shift register and sends it out most significant bit first on a single data line. Before capture, the word can be recoded from straight binary to two's complement.

The port has two clocking modes. In internal-clock mode it divides the system clock to make its own serial clock. It sends one burst of exactly one word's worth of clock pulses, framed by a sync output whose active level can be inverted. In external-clock mode the host supplies the serial clock. Chip select gates that clock, and an inversion input selects which host edge moves the data. If a new result arrives while a host read is only part done, the unread bits are dropped and a one-cycle error pulse is raised. The data line is driven only while chip select and read are both low. Otherwise it drives zero, which stands in for a released line.

Top module: `adc_serial_port`

## Requirements
- R1: While reset is held and in the first cycle after it, sdout_o, sclk_o and rd_error_o are 0 and sync_o equals sync_inv_i.
- R2: The captured word is sent most significant bit first. In internal mode the bit on sdout_o at each rising edge of sclk_o is the next bit of the word.
- R3: When twos_fmt_i is 1 at the latch, the most significant bit of the word is inverted before transmission, and all other bits are unchanged. When it is 0 the word is sent as given.
- R4: In internal mode one latch produces exactly DATA_W rising edges on sclk_o. Each high phase and each low phase lasts DIV system clocks.
- R5: In internal mode sync_o is at its active level from the cycle after the latch until the last sclk_o pulse ends, and is inactive afterwards. The active level is 1 when sync_inv_i is 0 and 0 when sync_inv_i is 1.
- R6: In external mode with sclk_inv_i at 0, the most significant bit is present after the latch. After the first host falling edge, each host rising edge advances sdout_o by one bit, and sdout_o holds steady up to the next falling edge.
- R7: In external mode with sclk_inv_i at 1, the roles of the edges swap. A falling host edge advances the data, and a rising edge is the sampling edge.
- R8: While cs_n_i is 1, host clock edges do not advance the read. After cs_n_i returns low, the full word is still available from its most significant bit.
- R9: sdout_o is 0 whenever cs_n_i or rd_n_i is 1.
- R10: In external mode, a latch that arrives after between 1 and DATA_W-1 sampling edges of the current word raises rd_error_o for exactly one cycle, and the new word then reads out in full. A latch before the first sampling edge or after all DATA_W sampling edges raises no error.
- R11: In external mode sclk_o stays 0 and sync_o stays at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| result_i | input | DATA_W | Conversion result in straight binary |
| latch_i | input | 1 | One-cycle strobe: capture result_i and start a new read |
| ext_mode_i | input | 1 | 0 = internal clock, 1 = external (host) clock |
| sclk_inv_i | input | 1 | External mode: 1 makes the falling host edge the update edge |
| sync_inv_i | input | 1 | 1 makes sync_o active low |
| twos_fmt_i | input | 1 | 1 selects two's complement coding |
| cs_n_i | input | 1 | Active-low chip select; also gates the host clock |
| rd_n_i | input | 1 | Active-low read; output enable together with cs_n_i |
| sclk_ext_i | input | 1 | Host serial clock (external mode) |
| sdout_o | output | 1 | Serial data, most significant bit first |
| sclk_o | output | 1 | Generated serial clock (internal mode) |
| sync_o | output | 1 | Frame sync (internal mode) |
| rd_error_o | output | 1 | One-cycle incomplete-read error pulse |

## Verification
The bench builds the port with DATA_W of 16 and DIV of 3. An odd divider means a phase length that is neither one cycle nor a power of two, so the phase counter's terminal compare and the high-time check of R4 meet a realistic case. It also keeps an internal burst short: 96 cycles. The host clock is driven at six system clocks per phase, which leaves room for the input synchronizer. That allows the bench to sample the data line twice between the update edge and the sampling edge, and it tests error latches at partial, complete and unstarted read depths.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;

    typedef enum logic {
        CLK_INTERNAL = 1'b0,
        CLK_EXTERNAL = 1'b1
    } clk_src_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_pair_t;

    typedef struct packed {
        logic load;
        logic shift;
    } sr_ctl_t;

    // Chooses the rising or falling edge depending on the inversion control.
    function automatic logic pick_edge(edge_pair_t e, logic inv);
        return inv ? e.fall : e.rise;
    endfunction

    // Level driven on a polarity-programmable strobe.
    function automatic logic polar_level(logic active, logic inv);
        return active ^ inv;
    endfunction

endpackage

// File: rtl/adc_sp_shreg.sv
module adc_sp_shreg
    import adc_sp_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  sr_ctl_t           ctl,
    input  logic [DATA_W-1:0] load_word,
    output logic              head
);

    logic [DATA_W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else if (ctl.load) begin
            sr_q <= load_word;
        end else if (ctl.shift) begin
            sr_q <= {sr_q[DATA_W-2:0], 1'b0};
        end
    end

    assign head = sr_q[DATA_W-1];

endmodule

// File: rtl/adc_sp_intclk.sv
module adc_sp_intclk #(
    parameter int DATA_W = 16,
    parameter int DIV    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic sclk,
    output logic shift,
    output logic frame
);

    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int PW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CW-1:0] PHASE_LAST = CW'(DIV - 1);
    localparam logic [PW-1:0] PULSE_LAST = PW'(DATA_W - 1);

    logic [CW-1:0] ph_cnt_q;
    logic [PW-1:0] pulse_q;
    logic          sclk_q;
    logic          frame_q;
    logic          phase_end;
    logic          last_pulse;

    assign phase_end  = frame_q && (ph_cnt_q == PHASE_LAST);
    assign last_pulse = (pulse_q == PULSE_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_cnt_q <= '0;
            pulse_q  <= '0;
            sclk_q   <= 1'b0;
            frame_q  <= 1'b0;
        end else if (start) begin
            ph_cnt_q <= '0;
            pulse_q  <= '0;
            sclk_q   <= 1'b0;
            frame_q  <= 1'b1;
        end else if (frame_q) begin
            if (phase_end) begin
                ph_cnt_q <= '0;
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                end else begin
                    sclk_q  <= 1'b0;
                    pulse_q <= pulse_q + 1'b1;
                    if (last_pulse) begin
                        frame_q <= 1'b0;
                    end
                end
            end else begin
                ph_cnt_q <= ph_cnt_q + 1'b1;
            end
        end
    end

    // Data advances with every falling edge except the one closing the burst.
    assign shift = phase_end && sclk_q && !last_pulse && !start;
    assign sclk  = sclk_q;
    assign frame = frame_q;

endmodule

// File: rtl/adc_sp_extclk.sv
module adc_sp_extclk
    import adc_sp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sclk_ext_i,
    input  logic cs_n_i,
    input  logic inv_i,
    output logic upd,
    output logic smp
);

    localparam int SYNC_STAGES = 3;

    logic                   gated;
    logic [SYNC_STAGES-1:0] pipe_q;
    edge_pair_t             edges;

    // With chip select high the clock is parked at its idle level.
    assign gated = cs_n_i ? inv_i : sclk_ext_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= {SYNC_STAGES{inv_i}};
        end else begin
            pipe_q <= {pipe_q[SYNC_STAGES-2:0], gated};
        end
    end

    assign edges.rise = pipe_q[SYNC_STAGES-2] && !pipe_q[SYNC_STAGES-1];
    assign edges.fall = !pipe_q[SYNC_STAGES-2] && pipe_q[SYNC_STAGES-1];

    assign upd = pick_edge(edges, inv_i);
    assign smp = pick_edge(edges, !inv_i);

endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
    import adc_sp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DIV    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] result_i,
    input  logic              latch_i,
    input  logic              ext_mode_i,
    input  logic              sclk_inv_i,
    input  logic              sync_inv_i,
    input  logic              twos_fmt_i,
    input  logic              cs_n_i,
    input  logic              rd_n_i,
    input  logic              sclk_ext_i,
    output logic              sdout_o,
    output logic              sclk_o,
    output logic              sync_o,
    output logic              rd_error_o
);

    localparam int RC_W = $clog2(DATA_W + 1);
    localparam logic [RC_W-1:0] RC_FULL = RC_W'(DATA_W);

    clk_src_e          src;
    logic [DATA_W-1:0] coded_word;
    sr_ctl_t           sr_ctl;
    logic              head;
    logic              int_sclk, int_shift, int_frame;
    logic              ext_upd, ext_smp;
    logic [RC_W-1:0]   rd_cnt_q;
    logic              read_partial;
    logic              err_q;
    logic              is_ext;
    logic              out_en;

    assign src    = clk_src_e'(ext_mode_i);
    assign is_ext = (src == CLK_EXTERNAL);

    // Offset-binary to two's complement: only the top bit flips.
    assign coded_word = {result_i[DATA_W-1] ^ twos_fmt_i, result_i[DATA_W-2:0]};

    adc_sp_intclk #(
        .DATA_W (DATA_W),
        .DIV    (DIV)
    ) intclk_i (
        .clk   (clk),
        .rst   (rst),
        .start (latch_i && !is_ext),
        .sclk  (int_sclk),
        .shift (int_shift),
        .frame (int_frame)
    );

    adc_sp_extclk extclk_i (
        .clk        (clk),
        .rst        (rst),
        .sclk_ext_i (sclk_ext_i),
        .cs_n_i     (cs_n_i),
        .inv_i      (sclk_inv_i),
        .upd        (ext_upd),
        .smp        (ext_smp)
    );

    // Sampling edges taken from the current word in external mode.
    always_ff @(posedge clk) begin
        if (rst || latch_i) begin
            rd_cnt_q <= '0;
        end else if (is_ext && ext_smp && (rd_cnt_q != RC_FULL)) begin
            rd_cnt_q <= rd_cnt_q + 1'b1;
        end
    end

    assign read_partial = (rd_cnt_q != '0) && (rd_cnt_q != RC_FULL);

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else begin
            err_q <= latch_i && is_ext && read_partial;
        end
    end

    // The first update edge only presents the top bit already on the line.
    always_comb begin
        sr_ctl.load  = latch_i;
        sr_ctl.shift = is_ext ? (ext_upd && (rd_cnt_q != '0)) : int_shift;
    end

    adc_sp_shreg #(
        .DATA_W (DATA_W)
    ) shreg_i (
        .clk       (clk),
        .rst       (rst),
        .ctl       (sr_ctl),
        .load_word (coded_word),
        .head      (head)
    );

    assign out_en     = !cs_n_i && !rd_n_i;
    assign sdout_o    = out_en && head && (is_ext || int_frame);
    assign sclk_o     = !is_ext && int_sclk;
    assign sync_o     = polar_level(!is_ext && int_frame, sync_inv_i);
    assign rd_error_o = err_q;

endmodule

// File: rtl/adc_sp_chk.sv
module adc_sp_chk #(
    parameter int DIV = 4
) (
    input logic clk,
    input logic rst,
    input logic ext_mode_i,
    input logic sync_inv_i,
    input logic cs_n_i,
    input logic rd_n_i,
    input logic latch_i,
    input logic sdout_o,
    input logic sclk_o,
    input logic sync_o,
    input logic rd_error_o
);

    localparam int HW = $clog2(DIV + 2) + 1;

    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst || !sclk_o) begin
            hi_cnt <= '0;
        end else begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    assert_sdout_gated_R9: assert property (@(posedge clk) disable iff (rst)
        (cs_n_i || rd_n_i) |-> !sdout_o);

    assert_err_single_R10: assert property (@(posedge clk) disable iff (rst)
        rd_error_o |=> !rd_error_o);

    assert_err_after_latch_R10: assert property (@(posedge clk) disable iff (rst)
        rd_error_o |-> ($past(latch_i) && $past(ext_mode_i)));

    assert_high_time_R4: assert property (@(posedge clk) disable iff (rst)
        (!ext_mode_i && $fell(sclk_o) && !$past(latch_i)) |-> (hi_cnt == HW'(DIV)));

    assert_sync_framing_R5: assert property (@(posedge clk) disable iff (rst)
        (!ext_mode_i && $rose(sclk_o)) |-> (sync_o != sync_inv_i));

    assert_ext_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        (ext_mode_i && $past(ext_mode_i)) |-> (!sclk_o && (sync_o == sync_inv_i)));

endmodule

bind adc_serial_port adc_sp_chk #(.DIV(DIV)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .ext_mode_i (ext_mode_i),
    .sync_inv_i (sync_inv_i),
    .cs_n_i     (cs_n_i),
    .rd_n_i     (rd_n_i),
    .latch_i    (latch_i),
    .sdout_o    (sdout_o),
    .sclk_o     (sclk_o),
    .sync_o     (sync_o),
    .rd_error_o (rd_error_o)
);

// File: tb/adc_serial_port_tb_top.sv
module adc_serial_port_tb_top;

    localparam int DATA_W = 16;
    localparam int DIV    = 3;
    localparam int HALF   = 6;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [DATA_W-1:0] result_i = '0;
    logic              latch_i = 1'b0;
    logic              ext_mode_i = 1'b0;
    logic              sclk_inv_i = 1'b0;
    logic              sync_inv_i = 1'b0;
    logic              twos_fmt_i = 1'b0;
    logic              cs_n_i = 1'b0;
    logic              rd_n_i = 1'b0;
    logic              sclk_ext_i = 1'b0;
    logic              sdout_o, sclk_o, sync_o, rd_error_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    adc_serial_port #(.DATA_W(DATA_W), .DIV(DIV)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .result_i   (result_i),
        .latch_i    (latch_i),
        .ext_mode_i (ext_mode_i),
        .sclk_inv_i (sclk_inv_i),
        .sync_inv_i (sync_inv_i),
        .twos_fmt_i (twos_fmt_i),
        .cs_n_i     (cs_n_i),
        .rd_n_i     (rd_n_i),
        .sclk_ext_i (sclk_ext_i),
        .sdout_o    (sdout_o),
        .sclk_o     (sclk_o),
        .sync_o     (sync_o),
        .rd_error_o (rd_error_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] coded(input logic [DATA_W-1:0] w, input logic twos);
        logic [DATA_W-1:0] r;
        r = w;
        if (twos) r[DATA_W-1] = ~r[DATA_W-1];
        return r;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic latch_word(input logic [DATA_W-1:0] w, output logic e1, output logic e2);
        @(negedge clk);
        result_i = w;
        latch_i  = 1'b1;
        @(negedge clk);
        latch_i  = 1'b0;
        e1 = rd_error_o;
        @(negedge clk);
        e2 = rd_error_o;
    endtask

    task automatic ext_setup(input logic inv, input logic twos);
        ext_mode_i = 1'b1;
        sclk_inv_i = inv;
        sclk_ext_i = inv;
        twos_fmt_i = twos;
        cs_n_i = 1'b0;
        rd_n_i = 1'b0;
        do_reset();
    endtask

    // Host read of nbits; each bit is sampled twice between update and sample edge.
    task automatic ext_read(input int nbits, output logic [DATA_W-1:0] got,
                            output int unstable, output int quiet_bad);
        logic a, b;
        got = '0;
        unstable = 0;
        quiet_bad = 0;
        for (int i = 0; i < nbits; i++) begin
            sclk_ext_i = ~sclk_inv_i;
            repeat (4) @(negedge clk);
            a = sdout_o;
            repeat (HALF - 4) @(negedge clk);
            b = sdout_o;
            if (a !== b) unstable++;
            if (sclk_o !== 1'b0 || sync_o !== sync_inv_i) quiet_bad++;
            got = {got[DATA_W-2:0], b};
            sclk_ext_i = sclk_inv_i;
            repeat (HALF) @(negedge clk);
        end
    endtask

    task automatic test_reset();
        sync_inv_i = 1'b1;
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 sdout in reset", sdout_o, 0);
        check("R1 sync idle in reset", sync_o, 1);
        rst = 1'b0;
        @(negedge clk);
        check("R1 sclk after reset", sclk_o, 0);
        check("R1 error after reset", rd_error_o, 0);
        sync_inv_i = 1'b0;
    endtask

    task automatic int_read(input logic [DATA_W-1:0] w, input logic twos, input logic sinv);
        logic [DATA_W-1:0] got;
        int rises, hi, lo, phase_bad, sync_bad;
        logic prev;
        logic e1, e2;
        ext_mode_i = 1'b0;
        sclk_inv_i = 1'b0;
        sync_inv_i = sinv;
        twos_fmt_i = twos;
        cs_n_i = 1'b0;
        rd_n_i = 1'b0;
        do_reset();
        latch_word(w, e1, e2);
        got = '0; rises = 0; hi = 0; lo = 1; phase_bad = 0; sync_bad = 0;
        prev = 1'b0;
        for (int c = 0; c < 2 * DIV * DATA_W + 8; c++) begin
            if (sclk_o && !prev) begin
                got = {got[DATA_W-2:0], sdout_o};
                rises++;
                if (sync_o !== ~sinv) sync_bad++;
            end
            if (sclk_o) begin
                if (!prev && rises > 1 && lo != DIV) phase_bad++;
                hi++; lo = 0;
            end else begin
                if (prev && hi != DIV) phase_bad++;
                lo++; hi = 0;
            end
            prev = sclk_o;
            @(negedge clk);
        end
        check("R2 word shifted out", got, coded(w, twos));
        check("R4 rising edge count", rises, DATA_W);
        check("R4 phase lengths", phase_bad, 0);
        check("R5 sync active at pulses", sync_bad, 0);
        check("R5 sync inactive after burst", sync_o, sinv);
    endtask

    task automatic test_int_disabled();
        int hot;
        logic e1, e2;
        ext_mode_i = 1'b0;
        twos_fmt_i = 1'b0;
        cs_n_i = 1'b0;
        rd_n_i = 1'b1;
        do_reset();
        latch_word('1, e1, e2);
        hot = 0;
        for (int c = 0; c < 2 * DIV * DATA_W; c++) begin
            @(negedge clk);
            if (sdout_o) hot++;
        end
        check("R9 sdout held low with read high", hot, 0);
        rd_n_i = 1'b0;
    endtask

    task automatic test_ext(input logic inv, input logic twos, input logic [DATA_W-1:0] w);
        logic [DATA_W-1:0] got;
        int uns, qb;
        logic e1, e2;
        ext_setup(inv, twos);
        latch_word(w, e1, e2);
        ext_read(DATA_W, got, uns, qb);
        if (inv) begin
            check("R7 inverted edge readout", got, coded(w, twos));
            check("R7 data stable before sample edge", uns, 0);
        end else begin
            check("R6 rising update readout", got, coded(w, twos));
            check("R6 data stable before sample edge", uns, 0);
        end
        check("R11 sclk_o low and sync idle", qb, 0);
    endtask

    task automatic test_cs_gate();
        logic [DATA_W-1:0] got;
        int uns, qb, hot;
        logic e1, e2;
        ext_setup(1'b1, 1'b0);
        latch_word(16'hA55A, e1, e2);
        cs_n_i = 1'b1;
        hot = 0;
        for (int i = 0; i < 3; i++) begin
            sclk_ext_i = 1'b0;
            repeat (HALF) @(negedge clk);
            if (sdout_o) hot++;
            sclk_ext_i = 1'b1;
            repeat (HALF) @(negedge clk);
        end
        check("R9 sdout low with chip select high", hot, 0);
        cs_n_i = 1'b0;
        repeat (4) @(negedge clk);
        ext_read(DATA_W, got, uns, qb);
        check("R8 gated edges did not advance", got, 16'hA55A);
    endtask

    task automatic test_error();
        logic [DATA_W-1:0] got;
        int uns, qb;
        logic e1, e2;
        ext_setup(1'b0, 1'b0);
        latch_word(16'h1234, e1, e2);
        latch_word(16'hC3A1, e1, e2);
        check("R10 no error before read starts", {e1, e2}, 0);
        ext_read(5, got, uns, qb);
        check("R10 partial bits", got[4:0], 5'b11000);
        latch_word(16'h0F0F, e1, e2);
        check("R10 error pulse raised", e1, 1);
        check("R10 error pulse one cycle", e2, 0);
        ext_read(DATA_W, got, uns, qb);
        check("R10 new word after error", got, 16'h0F0F);
        latch_word(16'h7777, e1, e2);
        check("R10 no error after complete read", {e1, e2}, 0);
        ext_read(DATA_W, got, uns, qb);
        check("R10 following word intact", got, 16'h7777);
    endtask

    initial begin
        test_reset();
        int_read(16'hB2C5, 1'b0, 1'b0);
        int_read(16'h1234, 1'b1, 1'b1);
        int_read(16'h8000, 1'b1, 1'b0);
        check("R3 two's complement of midscale", coded(16'h8000, 1'b1), 16'h0000);
        test_int_disabled();
        test_ext(1'b0, 1'b0, 16'h9E37);
        test_ext(1'b1, 1'b0, 16'h4C01);
        test_ext(1'b0, 1'b1, 16'h7FFF);
        test_cs_gate();
        test_error();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule